// File: doc/BRIEF.md
# Two-Wire Register Access Slave with Auto-Incrementing Index

This block is a slave on a two-wire serial bus (I2C-style clock and data lines, both open-drain with pull-ups). It lets an external host read and write an internal bank of 256 eight-bit registers. The block runs on a fast system clock and oversamples the bus: both lines pass through a two-flop synchronizer, and edge detection then finds clock edges and start and stop conditions. The system clock must run at least about eight times the bus clock rate.

After a start condition, the host sends a byte that holds the fixed 7-bit device address and a direction bit. In a write, the first byte after the address loads an 8-bit index pointer. Each later byte is written through the register-file port to the entry that the pointer selects, and the pointer then advances by one. In a read, the slave shifts out the entry at the current pointer, advances the pointer, and repeats until the host answers with a not-acknowledge. A host can therefore write a burst of ascending registers, then issue a repeated start and read them back, with only one index phase.

The block never drives the data line high. Its only output to the bus is a pull-low enable, and that enable changes only after a falling bus clock edge. The register file sits outside the block and is reached through an index, write-data, write-strobe and read-data port.

Top module: `i2c_idx_slave`

## Requirements
- R1: A start condition (data falling while the clock is high) restarts byte framing from any state, including in the middle of a byte, and the next byte is treated as an address byte.
- R2: The first byte after a start holds a 7-bit device address (bits 7..1, MSB first) and a direction bit (bit 0: 1 = read, 0 = write). On a match with DEV_ADDR, the slave pulls data low during the ninth clock pulse. On a mismatch it leaves data released and ignores the rest of the transfer: no register writes occur.
- R3: In a write transfer, the first byte after the address loads the index pointer and is acknowledged.
- R4: Each later write byte is acknowledged and written once, through a single-cycle strobe, to the entry at the pointer. The pointer then advances by one, so a burst fills ascending entries.
- R5: The 8-bit pointer wraps from 255 to 0.
- R6: In a read transfer, the slave returns the entry at the current pointer, MSB first, and advances the pointer after each byte. A read that follows a previous access without a new index phase continues at the pointer that access left.
- R7: When the host answers a read byte with a not-acknowledge (data high on the ninth pulse), the slave releases data and stays released until the next start or stop.
- R8: A stop condition (data rising while the clock is high) returns the slave to idle with data released.
- R9: The pull-low enable changes only in the cycle after a falling bus clock edge, a start or a stop, so data is stable while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least about 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_pull | output | 1 | When high, pull the data line low; otherwise release it |
| reg_idx | output | 8 | Index pointer; selects the register-file entry |
| reg_wdata | output | 8 | Byte to write to the entry at reg_idx |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Contents of the entry at reg_idx |

## Verification
Each bus line passes through two synchronizer flops and one more register for edge detection. The slave's response to a bus edge therefore appears on sda_pull about three system cycles after the bench moves the line. The bench holds each bus clock phase for eight system cycles and samples data at the middle of the high phase, well after that latency has settled. The write strobe and pointer advance fall a few cycles after the eighth falling edge, and the register-file model is compared only after the following stop. The released state after a not-acknowledge is checked half a phase after the ninth falling edge.

// File: rtl/i2c_idx_slave.sv
module i2c_idx_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  output logic [7:0] reg_idx,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_IDX, S_WR, S_RD, S_HOLD} state_t;

  state_t      state;
  logic [2:0]  scl_s, sda_s;
  logic [3:0]  cnt;
  logic [7:0]  sr, tx;
  logic        rw, host_nack;

  wire scl_rise = scl_s[1] & ~scl_s[2];
  wire scl_fall = ~scl_s[1] & scl_s[2];
  wire start    = scl_s[1] & scl_s[2] & sda_s[2] & ~sda_s[1];
  wire stop     = scl_s[1] & scl_s[2] & ~sda_s[2] & sda_s[1];
  wire active   = (state != S_IDLE) && (state != S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 3'b111;
      sda_s <= 3'b111;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      host_nack <= 1'b0;
      sda_pull  <= 1'b0;
      reg_idx   <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) reg_idx <= reg_idx + 8'd1;
      if (start) begin
        state    <= S_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop) begin
        state    <= S_IDLE;
        sda_pull <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8) sr <= {sr[6:0], sda_s[1]};
          if (cnt == 4'd8) host_nack <= sda_s[1];
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            case (state)
              S_ADDR:
                if (sr[7:1] == DEV_ADDR) begin
                  sda_pull <= 1'b1;
                  rw       <= sr[0];
                end else begin
                  state <= S_IDLE;
                end
              S_IDX: begin
                reg_idx  <= sr;
                sda_pull <= 1'b1;
              end
              S_WR: begin
                reg_wdata <= sr;
                reg_we    <= 1'b1;
                sda_pull  <= 1'b1;
              end
              S_RD: begin
                sda_pull <= 1'b0;
                reg_idx  <= reg_idx + 8'd1;
              end
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            cnt      <= '0;
            sda_pull <= 1'b0;
            case (state)
              S_ADDR:
                if (rw) begin
                  state    <= S_RD;
                  tx       <= reg_rdata;
                  sda_pull <= ~reg_rdata[7];
                end else begin
                  state <= S_IDX;
                end
              S_IDX: state <= S_WR;
              S_RD:
                if (host_nack) begin
                  state <= S_HOLD;
                end else begin
                  tx       <= reg_rdata;
                  sda_pull <= ~reg_rdata[7];
                end
              default: ;
            endcase
          end else if (state == S_RD && cnt != 4'd0) begin
            tx       <= {tx[6:0], 1'b0};
            sda_pull <= ~tx[6];
          end
        end
      end
    end
  end

  AST_START_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == S_ADDR && cnt == 4'd0)); // R1
  AST_MISMATCH_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !reg_we); // R2
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R4
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_idx == $past(reg_idx) + 8'd1)); // R5
  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD) |-> !sda_pull); // R7
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == S_IDLE && !sda_pull)); // R8
  AST_PULL_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall || start || stop)); // R9

endmodule

// File: tb/i2c_idx_slave_tb.sv
module i2c_idx_slave_tb_top;
  localparam logic [6:0] ADDR = 7'h44;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, reg_we;
  logic [7:0] reg_idx, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  int checks = 0, fails = 0, we_cnt = 0;
  bit done = 1'b0;

  wire sda_line = sda_m & ~sda_pull;
  assign reg_rdata = mem[reg_idx];

  always #4 clk = ~clk;

  i2c_idx_slave #(.DEV_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull(sda_pull), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata));

  always @(posedge clk) if (reg_we) begin
    mem[reg_idx] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(int n); repeat (n) @(negedge clk); endtask

  task automatic do_start();
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b0; wt(H); scl_m = 1'b0; wt(H);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wt(H); scl_m = 1'b1; wt(H); sda_m = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
    end
    sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H/2);
    acked = !sda_line;
    wt(H/2); scl_m = 1'b0; wt(2);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(H); scl_m = 1'b1; wt(H/2); b = {b[6:0], sda_line}; wt(H/2); scl_m = 1'b0;
    end
    wt(2); sda_m = nack; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2); sda_m = 1'b1;
  endtask

  task automatic check_mem(string req);
    int bad = 0, first = 0;
    for (int i = 255; i >= 0; i--) if (mem[i] !== expm[i]) begin bad++; first = i; end
    chk(bad == 0, req, bad == 0 ? 0 : int'(mem[first]), int'(expm[first]));
  endtask

  task automatic wr_burst(logic [7:0] idx, int n, string req);
    bit a;
    logic [7:0] d;
    do_start();
    send_byte({ADDR, 1'b0}, a); chk(a, "R2 addr ack", a, 1);
    send_byte(idx, a);          chk(a, "R3 index ack", a, 1);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, a); chk(a, "R4 data ack", a, 1);
      expm[8'(idx + k)] = d;
    end
    do_stop();
    check_mem(req);
  endtask

  task automatic rd_burst(logic [7:0] idx, bit set_idx, int n, string req);
    bit a;
    logic [7:0] d;
    do_start();
    if (set_idx) begin
      send_byte({ADDR, 1'b0}, a);
      send_byte(idx, a);
      do_start();
    end
    send_byte({ADDR, 1'b1}, a); chk(a, "R2 read addr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, d);
      chk(d === expm[8'(idx + k)], req, d, expm[8'(idx + k)]);
    end
    wt(H/2);
    chk(!sda_pull, "R7 released after nack", sda_pull, 0);
    do_stop();
    chk(!sda_pull, "R8 released after stop", sda_pull, 0);
  endtask

  initial begin
    bit a;
    logic [7:0] ix;
    int n, w0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i ^ 8'h5A); expm[i] = 8'(i ^ 8'h5A); end
    wt(5); rst_n = 1'b1; wt(3);
    chk(!sda_pull, "R8 reset released", sda_pull, 0);
    chk(!reg_we, "R4 reset strobe", reg_we, 0);
    chk(reg_idx == 0, "R3 reset index", reg_idx, 0);

    wr_burst(8'h10, 4, "R4 burst write");
    rd_burst(8'h10, 1'b1, 4, "R6 read back");
    rd_burst(8'h14, 1'b0, 2, "R6 continue at pointer");

    wr_burst(8'hFE, 4, "R5 wrap write");
    rd_burst(8'hFD, 1'b1, 5, "R5 wrap read");

    w0 = we_cnt;
    do_start();
    send_byte({7'h21, 1'b0}, a); chk(!a, "R2 mismatch no ack", a, 0);
    send_byte(8'h30, a); send_byte(8'hAA, a); send_byte(8'h55, a);
    chk(!a, "R2 mismatch data ignored", a, 0);
    do_stop();
    chk(we_cnt == w0, "R2 no writes on mismatch", we_cnt - w0, 0);
    check_mem("R2 mem untouched");

    do_start();
    send_byte({ADDR, 1'b0}, a);
    for (int i = 7; i >= 3; i--) begin
      sda_m = 1'b1; wt(H); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(2);
    end
    do_start();
    send_byte({ADDR, 1'b0}, a); chk(a, "R1 restart mid-byte ack", a, 1);
    send_byte(8'h40, a);
    send_byte(8'hC3, a); expm[8'h40] = 8'hC3;
    do_stop();
    check_mem("R1 write after restart");

    for (int t = 0; t < 12; t++) begin
      ix = 8'($urandom);
      n = 1 + int'($urandom % 6);
      wr_burst(ix, n, "R4 random write");
      rd_burst(ix, 1'b1, n, "R6 random read");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule